// File: doc/BRIEF.md
# Vector Mask Compress and Expand Unit

This unit keeps a per-element enable mask and applies it to one vector register image at a time. Three data operations are supported: a masked move that overwrites only the enabled elements of a destination image, a compress that packs the enabled source elements into a dense run starting at slot 0, and an expand that spreads a dense run of source elements onto the enabled destination positions. A fourth operation code turns every mask bit on. The number of enabled elements inside the active length is reported as the packed length.

The unit works through the vector one element per clock with an index counter and a single write pointer, so no full crossbar is built. A caller presents a source image, a destination image, a vector length and an operation code with a start pulse. The unit answers with a result image, the packed length and a one-cycle done pulse. The mask can be loaded from a comparison result through a separate write port while the unit is idle.

Top module: `vmx_unit`

## Requirements
- R1: The mask resets to all ones; when the unit is idle and `start` is low, `mask_wr` high loads `mask_in` into the mask, visible on `mask_q` from the next cycle.
- R2: Operation code 3 (set-all) turns every mask bit on; it raises `done` in the cycle after acceptance, leaves the result image equal to `dst_vec`, and reports a packed length of 0.
- R3: Operation code 0 (masked move): result element i equals source element i where i < `vlen` and mask bit i is 1, and destination element i otherwise.
- R4: Operation code 1 (compress): the source elements whose mask bit is 1 are written in ascending index order into result slots 0, 1, 2, and so on.
- R5: For compress, result slots at or above the packed length keep the destination element.
- R6: Operation code 2 (expand): source elements 0, 1, 2, and so on are placed in order at the result positions whose mask bit is 1.
- R7: For expand, positions whose mask bit is 0, or whose index is at or above `vlen`, keep the destination element.
- R8: For operation codes 0, 1 and 2, `packed_len` at `done` equals the number of mask bits set at indices below `vlen`.
- R9: Mask bits at indices at or above `vlen` affect neither the result image nor the packed length.
- R10: After `start` is accepted at a clock edge, `busy` is high and `done` low for `vlen` cycles, then `done` is high for exactly one cycle, then `busy` falls; with `vlen` = 0, `done` is high in the very next cycle.
- R11: While `busy` is high, including the done cycle, `start` and `mask_wr` are ignored: the running operation, its result and the mask are unchanged by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request an operation; taken only when idle |
| op | input | 2 | Operation: 0 move, 1 compress, 2 expand, 3 set-all |
| vlen | input | $clog2(NELEM+1) | Active vector length, 0 to NELEM |
| src_vec | input | NELEM*EW | Source image, element i at bits [i*EW +: EW] |
| dst_vec | input | NELEM*EW | Destination image, same layout |
| mask_wr | input | 1 | Load the mask from `mask_in` |
| mask_in | input | NELEM | Comparison result, bit i for element i |
| busy | output | 1 | Operation in progress, done cycle included |
| done | output | 1 | One-cycle completion pulse |
| result_vec | output | NELEM*EW | Result image, held until the next accepted operation |
| packed_len | output | $clog2(NELEM+1) | Enabled elements within the active length |
| mask_q | output | NELEM | Current mask contents |

## Verification
The bench builds the unit with NELEM = 8 and EW = 8, so every vector length from 0 up to the full register is cheap to run and the full-length case, where the write pointer and the index both reach the last slot, appears in several tests. With eight elements the mask patterns used (sparse, empty, full, alternating) put enabled bits on both sides of a shortened vector length, which brings the rule that bits beyond the length are ignored within reach. Stray start and mask writes are injected during a running operation to exercise the busy lockout.

// File: rtl/vmx_pkg.sv
// Shared types for the vector mask unit.
// Assumes: the operation encoding is fixed by the top-level port contract.
package vmx_pkg;

    typedef enum logic [1:0] {
        VMX_MOVE   = 2'd0,
        VMX_PACK   = 2'd1,
        VMX_UNPACK = 2'd2,
        VMX_SETALL = 2'd3
    } vmx_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } vmx_state_e;

endpackage

// File: rtl/vmx_ctrl.sv
// Sequencer: accepts an operation when idle, steps an element index once
// per cycle up to the latched length, then holds one done cycle.
// Assumes: vlen_in above NELEM is clamped to NELEM.
module vmx_ctrl
    import vmx_pkg::*;
#(
    parameter int NELEM = 64,
    parameter int LW    = $clog2(NELEM + 1),
    parameter int IW    = $clog2(NELEM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op_in,
    input  logic [LW-1:0] vlen_in,
    output logic          accept,
    output logic          run,
    output logic          done,
    output logic          busy,
    output logic [IW-1:0] idx,
    output vmx_op_e       op_q
);

    vmx_state_e    st_q;
    logic [LW-1:0] idx_q;
    logic [LW-1:0] vl_q;
    logic [LW-1:0] vl_eff;
    logic          last;
    vmx_op_e       op_dec;

    // Clamp the requested length to the register size.
    assign vl_eff = (vlen_in > LW'(NELEM)) ? LW'(NELEM) : vlen_in;
    assign op_dec = vmx_op_e'(op_in);
    assign accept = start && (st_q == ST_IDLE);
    assign last   = (idx_q == vl_q - LW'(1));

    // State, index and latched operation register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
            vl_q  <= '0;
            op_q  <= VMX_MOVE;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q  <= op_dec;
                        vl_q  <= vl_eff;
                        idx_q <= '0;
                        st_q  <= ((op_dec == VMX_SETALL) || (vl_eff == '0)) ? ST_DONE : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (last) begin
                        st_q <= ST_DONE;
                    end else begin
                        idx_q <= idx_q + LW'(1);
                    end
                end
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign run  = (st_q == ST_RUN);
    assign done = (st_q == ST_DONE);
    assign busy = (st_q != ST_IDLE);
    assign idx  = idx_q[IW-1:0];

endmodule

// File: rtl/vmx_mask_reg.sv
// Mask storage: one enable bit per element, all ones after reset.
// Assumes: set_all and load_en are never both high (set_all wins if so).
module vmx_mask_reg #(
    parameter int NELEM = 64,
    parameter int IW    = $clog2(NELEM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_all,
    input  logic             load_en,
    input  logic [NELEM-1:0] load_val,
    input  logic [IW-1:0]    idx,
    output logic             mbit,
    output logic [NELEM-1:0] mask_q
);

    // Mask register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (set_all) begin
            mask_q <= '1;
        end else if (load_en) begin
            mask_q <= load_val;
        end
    end

    // Enable bit of the element currently visited.
    assign mbit = mask_q[idx];

endmodule

// File: rtl/vmx_datapath.sv
// Element datapath: captures the images at acceptance, then per visited
// enabled element performs one write whose slot or source comes from a
// running count of enabled elements (write slot for compress, read slot
// for expand, the visited index otherwise).
// Assumes: run is only high for idx below the latched length.
module vmx_datapath
    import vmx_pkg::*;
#(
    parameter int NELEM = 64,
    parameter int EW    = 32,
    parameter int LW    = $clog2(NELEM + 1),
    parameter int IW    = $clog2(NELEM)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic                run,
    input  vmx_op_e             op,
    input  logic [IW-1:0]       idx,
    input  logic                mbit,
    input  logic [NELEM*EW-1:0] src_flat,
    input  logic [NELEM*EW-1:0] dst_flat,
    output logic [NELEM*EW-1:0] result_flat,
    output logic [LW-1:0]       cnt
);

    logic [EW-1:0] src_q [NELEM];
    logic [EW-1:0] res_q [NELEM];
    logic [LW-1:0] cnt_q;
    logic [IW-1:0] ptr;
    logic [IW-1:0] wr_sel;
    logic [EW-1:0] wr_data;
    logic          wr_en;

    assign ptr     = cnt_q[IW-1:0];
    assign wr_en   = run && mbit;
    assign wr_sel  = (op == VMX_PACK)   ? ptr        : idx;
    assign wr_data = (op == VMX_UNPACK) ? src_q[ptr] : src_q[idx];

    // Count of enabled elements visited so far in this operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= '0;
        end else if (wr_en) begin
            cnt_q <= cnt_q + LW'(1);
        end
    end

    for (genvar g = 0; g < NELEM; g++) begin : g_elem
        // Source element capture at acceptance.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_q[g] <= '0;
            end else if (accept) begin
                src_q[g] <= src_flat[g*EW +: EW];
            end
        end

        // Result element: seeded from the destination, then selectively written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q[g] <= '0;
            end else if (accept) begin
                res_q[g] <= dst_flat[g*EW +: EW];
            end else if (wr_en && (wr_sel == IW'(g))) begin
                res_q[g] <= wr_data;
            end
        end

        assign result_flat[g*EW +: EW] = res_q[g];
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/vmx_unit.sv
// Top of the vector mask unit: sequencer, mask register and element
// datapath. The mask port is honoured only when idle and not starting.
// Assumes: NELEM >= 2; vlen beyond NELEM is treated as NELEM.
module vmx_unit
    import vmx_pkg::*;
#(
    parameter int NELEM = 64,
    parameter int EW    = 32,
    localparam int LW   = $clog2(NELEM + 1),
    localparam int IW   = $clog2(NELEM)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          op,
    input  logic [LW-1:0]       vlen,
    input  logic [NELEM*EW-1:0] src_vec,
    input  logic [NELEM*EW-1:0] dst_vec,
    input  logic                mask_wr,
    input  logic [NELEM-1:0]    mask_in,
    output logic                busy,
    output logic                done,
    output logic [NELEM*EW-1:0] result_vec,
    output logic [LW-1:0]       packed_len,
    output logic [NELEM-1:0]    mask_q
);

    logic          accept;
    logic          run;
    logic [IW-1:0] idx;
    logic          mbit;
    logic          set_all;
    logic          load_en;
    vmx_op_e       op_q;

    assign set_all = accept && (vmx_op_e'(op) == VMX_SETALL);
    assign load_en = mask_wr && !busy && !start;

    vmx_ctrl #(.NELEM(NELEM), .LW(LW), .IW(IW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op_in   (op),
        .vlen_in (vlen),
        .accept  (accept),
        .run     (run),
        .done    (done),
        .busy    (busy),
        .idx     (idx),
        .op_q    (op_q)
    );

    vmx_mask_reg #(.NELEM(NELEM), .IW(IW)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_all  (set_all),
        .load_en  (load_en),
        .load_val (mask_in),
        .idx      (idx),
        .mbit     (mbit),
        .mask_q   (mask_q)
    );

    vmx_datapath #(.NELEM(NELEM), .EW(EW), .LW(LW), .IW(IW)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .run         (run),
        .op          (op_q),
        .idx         (idx),
        .mbit        (mbit),
        .src_flat    (src_vec),
        .dst_flat    (dst_vec),
        .result_flat (result_vec),
        .cnt         (packed_len)
    );

endmodule

// File: rtl/vmx_unit_chk.sv
// Property checker for vmx_unit, attached by bind.
// Assumes: the port contract of vmx_unit.
module vmx_unit_chk #(
    parameter int NELEM = 64,
    parameter int LW    = $clog2(NELEM + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [1:0]       op,
    input logic             mask_wr,
    input logic [NELEM-1:0] mask_in,
    input logic             busy,
    input logic             done,
    input logic [LW-1:0]    packed_len,
    input logic [NELEM-1:0] mask_q
);

    // R1: an idle mask write lands on the next cycle.
    a_r1_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && !busy && !start) |=> (mask_q == $past(mask_in)));

    // R2: an accepted set-all leaves every bit on.
    a_r2_set_all: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (op == 2'd3)) |=> (&mask_q));

    // R8: the packed length never exceeds the enabled bits.
    a_r8_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (32'(packed_len) <= $countones(mask_q)));

    // R10: done lasts one cycle and the unit is idle afterwards.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R11: the mask cannot move while an operation runs.
    a_r11_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mask_q));

endmodule

bind vmx_unit vmx_unit_chk #(.NELEM(NELEM), .LW(LW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op         (op),
    .mask_wr    (mask_wr),
    .mask_in    (mask_in),
    .busy       (busy),
    .done       (done),
    .packed_len (packed_len),
    .mask_q     (mask_q)
);

// File: tb/tb_vmx_unit.sv
module tb_vmx_unit;

    localparam int N  = 8;
    localparam int W  = 8;
    localparam int LW = $clog2(N + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [1:0]     op = 2'd0;
    logic [LW-1:0]  vlen = '0;
    logic [N*W-1:0] src_vec = '0;
    logic [N*W-1:0] dst_vec = '0;
    logic           mask_wr = 1'b0;
    logic [N-1:0]   mask_in = '0;
    logic           busy;
    logic           done;
    logic [N*W-1:0] result_vec;
    logic [LW-1:0]  packed_len;
    logic [N-1:0]   mask_q;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] ref_mask = '1;

    vmx_unit #(.NELEM(N), .EW(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .vlen(vlen),
        .src_vec(src_vec), .dst_vec(dst_vec), .mask_wr(mask_wr), .mask_in(mask_in),
        .busy(busy), .done(done), .result_vec(result_vec),
        .packed_len(packed_len), .mask_q(mask_q)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_mask(input logic [N-1:0] m);
        @(negedge clk);
        mask_wr = 1'b1;
        mask_in = m;
        @(negedge clk);
        mask_wr = 1'b0;
        ref_mask = m;
        chk(mask_q == m, "R1 mask load", 64'(mask_q), 64'(m));
    endtask

    // Behavioural reference plus per-cycle handshake comparison.
    task automatic run_op(input int opc, input int vl, input logic [N*W-1:0] s,
                          input logic [N*W-1:0] d, input bit disturb, input string req);
        logic [N*W-1:0] e;
        int c;
        int nrun;
        e = d;
        c = 0;
        if (opc == 3) begin
            ref_mask = '1;
        end else begin
            for (int i = 0; i < vl; i++) begin
                if (ref_mask[i]) begin
                    case (opc)
                        0: e[i*W +: W] = s[i*W +: W];
                        1: e[c*W +: W] = s[i*W +: W];
                        default: e[i*W +: W] = s[c*W +: W];
                    endcase
                    c++;
                end
            end
        end
        nrun = (opc == 3 || vl == 0) ? 0 : vl;
        @(negedge clk);
        start = 1'b1;
        op = 2'(opc);
        vlen = LW'(vl);
        src_vec = s;
        dst_vec = d;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < nrun; k++) begin
            if (disturb && k == 0) begin
                start = 1'b1;
                op = 2'((opc + 1) % 3);
                mask_wr = 1'b1;
                mask_in = ~ref_mask;
            end
            chk(busy && !done, "R10 running", {busy, done}, 2'b10);
            @(negedge clk);
            start = 1'b0;
            mask_wr = 1'b0;
        end
        chk(busy && done, "R10 done cycle", {busy, done}, 2'b11);
        chk(result_vec == e, req, result_vec, e);
        chk(packed_len == LW'(c), "R8 packed length", 64'(packed_len), 64'(c));
        @(negedge clk);
        chk(!busy && !done, "R10 idle after done", {busy, done}, 2'b00);
        chk(mask_q == ref_mask, "R11 mask after op", 64'(mask_q), 64'(ref_mask));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [N*W-1:0] sa;
        logic [N*W-1:0] da;
        sa = 64'h1716151413121110;
        da = 64'hA7A6A5A4A3A2A1A0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R10 reset idle", {busy, done}, 2'b00);
        chk(mask_q == '1, "R1 reset mask", 64'(mask_q), 64'hFF);
        chk(result_vec == '0 && packed_len == '0, "R8 reset outputs", result_vec, 64'h0);

        load_mask(8'b1011_0010);
        run_op(0, 8, sa, da, 1'b0, "R3 masked move");
        run_op(1, 8, sa, da, 1'b0, "R4 R5 compress full");
        run_op(1, 5, sa, da, 1'b0, "R9 R5 compress short");
        run_op(2, 8, sa, da, 1'b0, "R6 expand full");
        run_op(2, 6, sa, da, 1'b0, "R7 R9 expand short");
        run_op(0, 3, sa, da, 1'b0, "R9 R3 move short");
        run_op(1, 0, sa, da, 1'b0, "R10 zero length");
        run_op(0, 8, 64'h3837363534333231, da, 1'b1, "R11 move with stray start");

        load_mask(8'h00);
        run_op(1, 8, sa, da, 1'b0, "R5 compress empty mask");
        run_op(3, 8, sa, da, 1'b0, "R2 set all");
        run_op(1, 8, 64'hC7C6C5C4C3C2C1C0, da, 1'b0, "R4 compress full mask");

        load_mask(8'b0101_0101);
        run_op(2, 8, sa, 64'hF7F6F5F4F3F2F1F0, 1'b1, "R11 R6 expand with stray start");
        run_op(1, 7, 64'h5756555453525150, da, 1'b1, "R11 R4 compress with stray start");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule